// File: doc/BRIEF.md
# Tagged Link Word Adapter

This block sits between a chiplet's local write traffic and a valid/ready word stream toward the die-to-die link. Every link word is 48 bits wide and carries its own routing information: a 2-bit type in bits 47:46, a 14-bit destination offset in bits 45:32, and a 32-bit payload in bits 31:0.

On the transmit side, three write sources share one output. In priority order they are the returner (credit deltas and doorbells), the time-sync servo (timestamp words), and the CPU transmit aperture. Each source presents an offset and a payload. The returner and the servo produce sideband words. The aperture produces FIFO-data words. The chosen word is held in a single output register until the link accepts it.

On the receive side, each incoming word is routed only by its own type field. The block keeps no state from one word to the next. FIFO-data words become one-cycle writes on a direct FIFO port. Sideband words become register writes at the offset the word carries. Words with any other type are discarded and counted in a saturating counter.

Top module: `twa_adapter`

## Requirements
- R1: A granted aperture write leaves on `tx_word` as type 2'b00 (FIFO data), with `ap_off` in bits 45:32 and `ap_data` in bits 31:0.
- R2: A granted returner write leaves as type 2'b01 (sideband), with `ret_off` in bits 45:32 and `ret_data` in bits 31:0.
- R3: A granted servo write leaves as type 2'b01 (sideband), with `srv_off` in bits 45:32 and `srv_data` in bits 31:0.
- R4: When the output register is free (`tx_valid` low, or `tx_ready` high), exactly the highest-priority requester is granted in that same cycle, in the order returner, servo, aperture. At most one grant is high in any cycle, and no grant is given while the register is occupied and stalled. The granted word appears on `tx_word` with `tx_valid` high on the next cycle.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_word` does not change.
- R6: `ap_stall` is high exactly when `ap_wr` is high and the aperture is not granted in that cycle.
- R7: An `rx_valid` word of type 2'b00 produces, one cycle later, a single-cycle `fifo_we` pulse carrying the word's offset and payload. No register write occurs for that word.
- R8: An `rx_valid` word of type 2'b01 produces, one cycle later, a single-cycle `reg_we` pulse carrying the word's offset and payload. No FIFO write occurs for that word.
- R9: An `rx_valid` word of type 2'b10 or 2'b11 produces neither write. It increments `bad_cnt` one cycle later, and `bad_cnt` saturates at all ones.
- R10: After reset, `tx_valid`, `fifo_we`, `reg_we` and `bad_cnt` are zero.
- R11: Back-to-back receive words of different types are each routed only by their own type, with no influence from the word before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_req | input | 1 | Returner write request, held until granted |
| ret_off | input | 14 | Returner target register offset |
| ret_data | input | 32 | Returner payload |
| ret_gnt | output | 1 | Returner write accepted this cycle |
| srv_req | input | 1 | Servo sideband request, held until granted |
| srv_off | input | 14 | Servo target register offset |
| srv_data | input | 32 | Servo timestamp payload |
| srv_gnt | output | 1 | Servo write accepted this cycle |
| ap_wr | input | 1 | Aperture write, held while stalled |
| ap_off | input | 14 | Aperture word offset |
| ap_data | input | 32 | Aperture payload |
| ap_stall | output | 1 | Aperture write not accepted this cycle |
| tx_valid | output | 1 | Outgoing word valid |
| tx_word | output | 48 | Outgoing tagged word |
| tx_ready | input | 1 | Link accepts the outgoing word |
| rx_valid | input | 1 | Incoming word valid |
| rx_word | input | 48 | Incoming tagged word |
| fifo_we | output | 1 | Direct FIFO write strobe |
| fifo_off | output | 14 | Direct FIFO write offset |
| fifo_wdata | output | 32 | Direct FIFO write data |
| reg_we | output | 1 | Register write strobe |
| reg_off | output | 14 | Register write offset |
| reg_wdata | output | 32 | Register write data |
| bad_cnt | output | 8 | Saturating count of discarded receive words |

## Verification
The assertions check several rules on every cycle:
- the grant vector is one-hot or zero;
- a lower-priority grant never coincides with a higher-priority request;
- a stalled output word holds its value;
- the aperture stall matches the grant state;
- a receive word is routed one cycle later to the correct port;
- discarded words never produce a write;
- the two write strobes are never high together.

Other properties need the bench's scenarios and reference model:
- the exact word packing from each source;
- the order in which queued requests drain after a long stall;
- the counter stopping at its maximum;
- the independence of back-to-back receive words under random type mixes.

// File: rtl/twa_pkg.sv
// Package: shared type codes for the tagged link word.
// Assumes the type field occupies the top two bits of every word.
package twa_pkg;
    localparam int TYPE_W = 2;

    typedef enum logic [TYPE_W-1:0] {
        TY_FIFO = 2'b00,
        TY_SIDE = 2'b01,
        TY_RSV2 = 2'b10,
        TY_RSV3 = 2'b11
    } word_type_e;
endpackage

// File: rtl/twa_tx_merge.sv
// Module: fixed-priority merge of write sources into one tagged word.
// Source index 0 has the highest priority. A grant is only given when the
// output slot can take a word. Assumes that requesters hold their request
// and fields stable until they are granted.
module twa_tx_merge
    import twa_pkg::*;
#(
    parameter int NSRC   = 3,
    parameter int OFF_W  = 14,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           src_req,
    input  logic [NSRC*OFF_W-1:0]     src_off,
    input  logic [NSRC*DATA_W-1:0]    src_data,
    input  logic [NSRC*TYPE_W-1:0]    src_type,
    input  logic                      slot_free,
    output logic [NSRC-1:0]           src_gnt,
    output logic [TYPE_W+OFF_W+DATA_W-1:0] win_word
);
    localparam int WORD_W = TYPE_W + OFF_W + DATA_W;

    // Purpose: pick the lowest-index requester and build its word.
    always_comb begin
        logic taken;
        taken    = 1'b0;
        src_gnt  = '0;
        win_word = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_req[i] && !taken) begin
                src_gnt[i] = slot_free;
                win_word   = {src_type[i*TYPE_W +: TYPE_W],
                              src_off[i*OFF_W +: OFF_W],
                              src_data[i*DATA_W +: DATA_W]};
                taken      = 1'b1;
            end
        end
    end

    // R4: no two sources accepted together.
    p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_gnt));

    // R4: a granted source never has a higher-priority requester waiting.
    for (genvar g = 1; g < NSRC; g++) begin : g_prio_chk
        p_prio_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
            src_gnt[g] |-> !(|src_req[g-1:0]));
    end

    // R4: nothing is granted while the slot is blocked.
    p_no_gnt_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_free |-> (src_gnt == '0));

    logic [WORD_W-1:0] unused_w;
    assign unused_w = win_word;
endmodule

// File: rtl/twa_tx_slot.sv
// Module: single output register toward the link with valid/ready.
// It loads a new word whenever it is empty or being drained.
// Assumes that the link samples tx_word while tx_valid && tx_ready.
module twa_tx_slot #(
    parameter int WORD_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              tx_ready,
    output logic              slot_free,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_word
);
    // Purpose: the slot can accept a word when empty or when draining.
    assign slot_free = !tx_valid || tx_ready;

    // Purpose: hold the outgoing word until the link takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_word  <= '0;
        end else if (slot_free) begin
            tx_valid <= load;
            if (load) begin
                tx_word <= word_in;
            end
        end
    end

    // R5: a stalled word stays valid and unchanged.
    p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_word)));
endmodule

// File: rtl/twa_rx_demux.sv
// Module: stateless receive router for tagged link words.
// Each word is routed by its own type field, with one register stage.
// Reserved types are dropped and counted in a saturating counter.
// Assumes that the FIFO and register targets accept one write per cycle.
module twa_rx_demux
    import twa_pkg::*;
#(
    parameter int OFF_W  = 14,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rx_valid,
    input  logic [TYPE_W+OFF_W+DATA_W-1:0] rx_word,
    output logic                           fifo_we,
    output logic [OFF_W-1:0]               fifo_off,
    output logic [DATA_W-1:0]              fifo_wdata,
    output logic                           reg_we,
    output logic [OFF_W-1:0]               reg_off,
    output logic [DATA_W-1:0]              reg_wdata,
    output logic [CNT_W-1:0]               bad_cnt
);
    localparam int WORD_W  = TYPE_W + OFF_W + DATA_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [TYPE_W-1:0] f_type;
    logic [OFF_W-1:0]  f_off;
    logic [DATA_W-1:0] f_data;
    logic              is_fifo;
    logic              is_side;

    // Purpose: split the incoming word into its three fields.
    assign f_type  = rx_word[WORD_W-1 -: TYPE_W];
    assign f_off   = rx_word[DATA_W +: OFF_W];
    assign f_data  = rx_word[DATA_W-1:0];
    assign is_fifo = (f_type == TY_FIFO);
    assign is_side = (f_type == TY_SIDE);

    // Purpose: register the FIFO-side write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_we    <= 1'b0;
            fifo_off   <= '0;
            fifo_wdata <= '0;
        end else begin
            fifo_we    <= rx_valid && is_fifo;
            fifo_off   <= f_off;
            fifo_wdata <= f_data;
        end
    end

    // Purpose: register the register-side write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_we    <= 1'b0;
            reg_off   <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we    <= rx_valid && is_side;
            reg_off   <= f_off;
            reg_wdata <= f_data;
        end
    end

    // Purpose: count discarded words of reserved type, saturating at max.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_cnt <= '0;
        end else if (rx_valid && !is_fifo && !is_side && bad_cnt != CNT_MAX) begin
            bad_cnt <= bad_cnt + 1'b1;
        end
    end

    // R7: a data word becomes a FIFO write with its offset and payload.
    p_fifo_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_word[WORD_W-1 -: TYPE_W] == 2'b00) |=>
            (fifo_we && !reg_we && fifo_off == $past(rx_word[DATA_W +: OFF_W])
             && fifo_wdata == $past(rx_word[DATA_W-1:0])));

    // R8: a sideband word becomes a register write.
    p_reg_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_word[WORD_W-1 -: TYPE_W] == 2'b01) |=>
            (reg_we && !fifo_we && reg_off == $past(rx_word[DATA_W +: OFF_W])));

    // R9: reserved types produce no write.
    p_drop_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_word[WORD_W-1]) |=> (!fifo_we && !reg_we));

    // R9: the counter never wraps from full to zero.
    p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_cnt == CNT_MAX) |=> (bad_cnt == CNT_MAX));

    // R11: the two strobes are never high together.
    p_excl_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_we && reg_we));
endmodule

// File: rtl/twa_adapter.sv
// Module: top of the tagged link word adapter.
// Transmit: returner > servo > aperture merge into one output slot.
// Receive: stateless routing to a FIFO port or a register port.
// Assumes that returner and servo hold requests until granted, and that
// the aperture holds its write while ap_stall is high.
module twa_adapter
    import twa_pkg::*;
#(
    parameter int OFF_W  = 14,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ret_req,
    input  logic [OFF_W-1:0]               ret_off,
    input  logic [DATA_W-1:0]              ret_data,
    output logic                           ret_gnt,
    input  logic                           srv_req,
    input  logic [OFF_W-1:0]               srv_off,
    input  logic [DATA_W-1:0]              srv_data,
    output logic                           srv_gnt,
    input  logic                           ap_wr,
    input  logic [OFF_W-1:0]               ap_off,
    input  logic [DATA_W-1:0]              ap_data,
    output logic                           ap_stall,
    output logic                           tx_valid,
    output logic [TYPE_W+OFF_W+DATA_W-1:0] tx_word,
    input  logic                           tx_ready,
    input  logic                           rx_valid,
    input  logic [TYPE_W+OFF_W+DATA_W-1:0] rx_word,
    output logic                           fifo_we,
    output logic [OFF_W-1:0]               fifo_off,
    output logic [DATA_W-1:0]              fifo_wdata,
    output logic                           reg_we,
    output logic [OFF_W-1:0]               reg_off,
    output logic [DATA_W-1:0]              reg_wdata,
    output logic [CNT_W-1:0]               bad_cnt
);
    localparam int NSRC   = 3;
    localparam int WORD_W = TYPE_W + OFF_W + DATA_W;

    logic [NSRC-1:0]        req_v;
    logic [NSRC-1:0]        gnt_v;
    logic [NSRC*OFF_W-1:0]  off_v;
    logic [NSRC*DATA_W-1:0] data_v;
    logic [NSRC*TYPE_W-1:0] type_v;
    logic [WORD_W-1:0]      win_word;
    logic                   slot_free;

    // Purpose: order the sources by priority; index 0 wins.
    assign req_v  = {ap_wr, srv_req, ret_req};
    assign off_v  = {ap_off, srv_off, ret_off};
    assign data_v = {ap_data, srv_data, ret_data};
    assign type_v = {TY_FIFO, TY_SIDE, TY_SIDE};

    twa_tx_merge #(.NSRC(NSRC), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (req_v),
        .src_off  (off_v),
        .src_data (data_v),
        .src_type (type_v),
        .slot_free(slot_free),
        .src_gnt  (gnt_v),
        .win_word (win_word)
    );

    twa_tx_slot #(.WORD_W(WORD_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (|gnt_v),
        .word_in  (win_word),
        .tx_ready (tx_ready),
        .slot_free(slot_free),
        .tx_valid (tx_valid),
        .tx_word  (tx_word)
    );

    // Purpose: hand the grants back and stall an aperture write that lost.
    assign ret_gnt  = gnt_v[0];
    assign srv_gnt  = gnt_v[1];
    assign ap_stall = ap_wr && !gnt_v[2];

    twa_rx_demux #(.OFF_W(OFF_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word),
        .fifo_we   (fifo_we),
        .fifo_off  (fifo_off),
        .fifo_wdata(fifo_wdata),
        .reg_we    (reg_we),
        .reg_off   (reg_off),
        .reg_wdata (reg_wdata),
        .bad_cnt   (bad_cnt)
    );

    // R6: an aperture write that competes with a higher source is stalled.
    p_ap_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_wr && (ret_req || srv_req)) |-> ap_stall);

    // R1: an aperture grant leaves as a FIFO-data word.
    p_ap_type_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_wr && !ap_stall) |=> (tx_valid && tx_word[WORD_W-1 -: TYPE_W] == 2'b00));

    // R2: a returner grant leaves as a sideband word with its offset.
    p_ret_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ret_gnt |=> (tx_word[WORD_W-1 -: TYPE_W] == 2'b01
                     && tx_word[DATA_W +: OFF_W] == $past(ret_off)));

    // R3: a servo grant leaves as a sideband word.
    p_srv_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
        srv_gnt |=> (tx_word[WORD_W-1 -: TYPE_W] == 2'b01));
endmodule

// File: tb/tb_twa_adapter.sv
`timescale 1ns/1ps
module tb_twa_adapter;
    localparam int OFF_W  = 14;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam int WORD_W = 2 + OFF_W + DATA_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ret_req = 0, srv_req = 0, ap_wr = 0, tx_ready = 0, rx_valid = 0;
    logic [OFF_W-1:0]  ret_off = '0, srv_off = '0, ap_off = '0;
    logic [DATA_W-1:0] ret_data = '0, srv_data = '0, ap_data = '0;
    logic [WORD_W-1:0] rx_word = '0;
    logic ret_gnt, srv_gnt, ap_stall, tx_valid, fifo_we, reg_we;
    logic [WORD_W-1:0] tx_word;
    logic [OFF_W-1:0]  fifo_off, reg_off;
    logic [DATA_W-1:0] fifo_wdata, reg_wdata;
    logic [CNT_W-1:0]  bad_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model state.
    logic              m_valid = 0;
    logic [WORD_W-1:0] m_word  = '0;
    int                m_bad   = 0;
    bit e_ret, e_srv, e_ap;

    always #2.5 clk = ~clk;

    twa_adapter dut (
        .clk(clk), .rst_n(rst_n),
        .ret_req(ret_req), .ret_off(ret_off), .ret_data(ret_data), .ret_gnt(ret_gnt),
        .srv_req(srv_req), .srv_off(srv_off), .srv_data(srv_data), .srv_gnt(srv_gnt),
        .ap_wr(ap_wr), .ap_off(ap_off), .ap_data(ap_data), .ap_stall(ap_stall),
        .tx_valid(tx_valid), .tx_word(tx_word), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_word(rx_word),
        .fifo_we(fifo_we), .fifo_off(fifo_off), .fifo_wdata(fifo_wdata),
        .reg_we(reg_we), .reg_off(reg_off), .reg_wdata(reg_wdata),
        .bad_cnt(bad_cnt)
    );

    function automatic logic [WORD_W-1:0] mk_word(logic [1:0] ty, logic [OFF_W-1:0] o,
                                                  logic [DATA_W-1:0] d);
        return {ty, o, d};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: inputs are set before the call, just after a falling edge.
    task automatic step();
        bit free;
        bit e_fwe, e_rwe;
        logic [1:0] rty;
        #1;
        free  = !m_valid || tx_ready;
        e_ret = free && ret_req;
        e_srv = free && srv_req && !ret_req;
        e_ap  = free && ap_wr && !ret_req && !srv_req;
        chk(ret_gnt == e_ret, "R4", "ret_gnt", 64'(ret_gnt), 64'(e_ret));
        chk(srv_gnt == e_srv, "R4", "srv_gnt", 64'(srv_gnt), 64'(e_srv));
        chk(ap_stall == (ap_wr && !e_ap), "R6", "ap_stall", 64'(ap_stall), 64'(ap_wr && !e_ap));
        rty   = rx_word[WORD_W-1 -: 2];
        e_fwe = rx_valid && rty == 2'b00;
        e_rwe = rx_valid && rty == 2'b01;
        if (free) begin
            m_valid = e_ret || e_srv || e_ap;
            if (e_ret)      m_word = mk_word(2'b01, ret_off, ret_data);   // R2
            else if (e_srv) m_word = mk_word(2'b01, srv_off, srv_data);   // R3
            else if (e_ap)  m_word = mk_word(2'b00, ap_off, ap_data);     // R1
        end
        if (rx_valid && rty[1] && m_bad < (1 << CNT_W) - 1) m_bad++;
        @(negedge clk);
        chk(tx_valid == m_valid, "R5", "tx_valid", 64'(tx_valid), 64'(m_valid));
        if (m_valid) chk(tx_word == m_word, "R1", "tx_word", 64'(tx_word), 64'(m_word));
        chk(fifo_we == e_fwe, "R7", "fifo_we", 64'(fifo_we), 64'(e_fwe));
        chk(reg_we == e_rwe, "R8", "reg_we", 64'(reg_we), 64'(e_rwe));
        if (e_fwe) chk({fifo_off, fifo_wdata} == rx_word[OFF_W+DATA_W-1:0], "R7",
                       "fifo fields", 64'({fifo_off, fifo_wdata}),
                       64'(rx_word[OFF_W+DATA_W-1:0]));
        if (e_rwe) chk({reg_off, reg_wdata} == rx_word[OFF_W+DATA_W-1:0], "R8",
                       "reg fields", 64'({reg_off, reg_wdata}),
                       64'(rx_word[OFF_W+DATA_W-1:0]));
        chk(int'(bad_cnt) == m_bad, "R9", "bad_cnt", 64'(bad_cnt), 64'(m_bad));
        if (e_ret) ret_req = 0;
        if (e_srv) srv_req = 0;
        if (e_ap)  ap_wr   = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(!tx_valid && !fifo_we && !reg_we && bad_cnt == 0, "R10", "reset outputs",
            64'({tx_valid, fifo_we, reg_we, bad_cnt}), 64'd0);
        rst_n = 1;

        // R4/R5: all three request into a stalled link, then drain in order.
        ret_req = 1; ret_off = 14'h0123; ret_data = 32'hAAAA_0001;
        srv_req = 1; srv_off = 14'h2040; srv_data = 32'hBBBB_0002;
        ap_wr   = 1; ap_off  = 14'h3FFF; ap_data  = 32'hCCCC_0003;
        tx_ready = 0;
        repeat (4) step();
        tx_ready = 1;
        repeat (4) step();

        // R11: back-to-back receive words of alternating types.
        rx_valid = 1;
        rx_word = mk_word(2'b00, 14'h0001, 32'h1111_1111); step();
        rx_word = mk_word(2'b01, 14'h0002, 32'h2222_2222); step();
        rx_word = mk_word(2'b10, 14'h0003, 32'h3333_3333); step();
        rx_word = mk_word(2'b00, 14'h0004, 32'h4444_4444); step();
        rx_word = mk_word(2'b11, 14'h0005, 32'h5555_5555); step();
        rx_valid = 0; step();

        // Random mix on both paths.
        for (int n = 0; n < 3000; n++) begin
            if (!ret_req && ($urandom % 4 == 0)) begin
                ret_req = 1; ret_off = OFF_W'($urandom); ret_data = $urandom;
            end
            if (!srv_req && ($urandom % 3 == 0)) begin
                srv_req = 1; srv_off = OFF_W'($urandom); srv_data = $urandom;
            end
            if (!ap_wr && ($urandom % 2 == 0)) begin
                ap_wr = 1; ap_off = OFF_W'($urandom); ap_data = $urandom;
            end
            tx_ready = ($urandom % 3 != 0);
            rx_valid = ($urandom % 2 == 0);
            rx_word  = {$urandom, $urandom} [WORD_W-1:0];
            step();
        end

        // R9: saturation of the discard counter.
        ret_req = 0; srv_req = 0; ap_wr = 0;
        rx_valid = 1;
        for (int n = 0; n < 300; n++) begin
            rx_word = mk_word(2'b11, OFF_W'(n), 32'(n));
            step();
        end
        rx_valid = 0;
        step();
        chk(bad_cnt == '1, "R9", "saturated bad_cnt", 64'(bad_cnt), 64'hFF);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule